// File: doc/BRIEF.md
# SD card command/response register front-end

This block sits between a 32-bit word-addressed register bus and a card-side agent that carries out card commands and moves data bytes. Software builds a six-byte card command by writing one byte at a time to a command port. The sixth byte issues the command to the card agent. The card's answer is kept in a framed response buffer, and software reads it back one byte per access from the same port. A separate data port turns every 32-bit bus access into four byte transfers on byte-wide card streams. The most significant byte goes first in both directions.

Beside the two ports there are three plain storage registers (clock divider, start, enable) and a pending register. The pending register mirrors the receive-enable bits. A card-present input gates the command and data ports. Without a card, reads of those ports return all ones and writes to them do nothing.

The bus is a single valid/ready channel. An access completes in the cycle where `bus_valid` and `bus_ready` are both high, and read data is valid in that same cycle. The master must hold the address, direction and write data steady while `bus_valid` is high and `bus_ready` is low. Back-pressure appears in three places. A data port access waits for all four byte beats. The write that completes a command waits for the card's response. Every other access completes in its first cycle. The two byte streams follow the usual rules: a beat moves when valid and ready are both high, and the block holds `dat_tx_byte` stable while `dat_tx_valid` waits. `card_present` must not change while an access is in progress.

Top module: `sdcard_regfront`

## Requirements
- R1: After reset, word offsets 0 to 3 read 0, `cmd_req` is low, and with a card present the command port reads 0 repeatedly.
- R2: Offset 0 (clock divider), offset 3 (start) and offset 1 (enable) store and return all 32 written bits. Offsets 6 and 7 read 0, and writes to them change nothing.
- R3: Offset 2 (pending) holds only bits 1 and 3. After any write to enable or pending, pending equals enable AND 0xA. Writing 1s to pending cannot clear a bit whose enable is still set.
- R4: Each write to offset 4 keeps its low 8 bits. The sixth write raises `cmd_req` for exactly one cycle, with index = byte0 AND 0x3f, argument = bytes 1 to 4 (byte1 in bits 31:24) and CRC = byte5. That bus write completes in the cycle `cmd_rsp_valid` is seen.
- R5: A 16-byte card response is framed as 0x3f followed by the 16 bytes, giving a framed length of 17.
- R6: A 4-byte card response is framed as the index, the 4 bytes and a 0x00 byte, giving a framed length of 6. Any other count n is framed as the index followed by n bytes, with framed length n.
- R7: Reads of offset 4 return frame positions 0 to L in turn, where L is the framed length, and then start again at 0. Positions past the stored bytes read 0. Issuing a command restarts the read position at 0.
- R8: After a command with index 0 has been issued, the next write to offset 4 is dropped, and the write after that becomes byte0 of a new command.
- R9: A read of offset 5 takes four bytes from the receive stream and places the first in bits 31:24 and the last in bits 7:0.
- R10: A write to offset 5 sends bits 31:24 first and bits 7:0 last on the transmit stream, holding each byte stable until it is accepted.
- R11: With `card_present` low, offset 4 reads 0xff and offset 5 reads 0xffffffff without any stream beat. Writes to offsets 4 and 5 complete without touching the stream, the command position or the read position.
- R12: An access completes only in a cycle with `bus_valid` and `bus_ready` both high, and `bus_rdata` is valid in that cycle. Register accesses complete in their first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| card_present | input | 1 | High when a card is attached |
| bus_valid | input | 1 | Bus access request |
| bus_ready | output | 1 | Access completes this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| cmd_req | output | 1 | One-cycle command issue strobe |
| cmd_index | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_crc | output | 8 | Command check byte |
| cmd_rsp_valid | input | 1 | Card response available |
| cmd_rsp_len | input | 5 | Card response byte count (0 to 16) |
| cmd_rsp_data | input | 128 | Response bytes, first byte in bits 7:0 |
| dat_tx_valid | output | 1 | Transmit byte valid |
| dat_tx_ready | input | 1 | Card accepts transmit byte |
| dat_tx_byte | output | 8 | Transmit byte |
| dat_rx_valid | input | 1 | Receive byte valid |
| dat_rx_ready | output | 1 | Block accepts receive byte |
| dat_rx_byte | input | 8 | Receive byte |

## Verification
Two events can land in one cycle: the card's response arriving and the acknowledgement of the final command byte. When they do, the response buffer is loaded, both positions are reset and the ignore flag is armed, all in that single cycle. The card model in the bench answers after zero to three cycles. With zero delay the response is present in the very cycle `cmd_req` is high. Each such case is judged by reading the framed bytes back right away and comparing them with a frame the bench builds on its own. On the data port, the last byte beat and the word's completion also share a cycle. Random valid and ready gaps on both streams provoke this, and the bench checks the returned word and the logged transmit bytes.

// File: rtl/sdf_pkg.sv
`timescale 1ns/1ps
package sdf_pkg;
  localparam int unsigned CMD_BYTES = 6;
  localparam int unsigned IDX_W     = 6;
  localparam int unsigned RSP_SHORT = 4;
  localparam logic [7:0]  LONG_LEAD = 8'h3f;
  localparam logic [3:0]  PEND_MASK = 4'b1010;

  typedef enum logic [2:0] {
    OFS_DIV   = 3'd0,
    OFS_EN    = 3'd1,
    OFS_PEND  = 3'd2,
    OFS_START = 3'd3,
    OFS_CMD   = 3'd4,
    OFS_DAT   = 3'd5
  } reg_ofs_e;
endpackage

// File: rtl/sdf_regs.sv
`timescale 1ns/1ps
module sdf_regs #(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data
);
  import sdf_pkg::*;

  localparam logic [DATA_W-1:0] PMASK = DATA_W'(PEND_MASK);

  logic [DATA_W-1:0] div_q, en_q, pend_q, start_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q   <= '0;
      en_q    <= '0;
      pend_q  <= '0;
      start_q <= '0;
    end else if (wr_en) begin
      if (addr == ADDR_W'(OFS_DIV))   div_q   <= wdata;
      if (addr == ADDR_W'(OFS_START)) start_q <= wdata;
      if (addr == ADDR_W'(OFS_EN)) begin
        en_q   <= wdata;
        pend_q <= wdata & PMASK;
      end
      // clearing the written bits is overridden by the recompute from enable
      if (addr == ADDR_W'(OFS_PEND)) pend_q <= en_q & PMASK;
    end
  end

  always_comb begin
    rd_data = '0;
    if (addr == ADDR_W'(OFS_DIV))   rd_data = div_q;
    if (addr == ADDR_W'(OFS_EN))    rd_data = en_q;
    if (addr == ADDR_W'(OFS_PEND))  rd_data = pend_q;
    if (addr == ADDR_W'(OFS_START)) rd_data = start_q;
  end

  AST_PEND_SUBSET_OF_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & ~(en_q & PMASK)) == '0); // R3
  AST_PEND_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(pend_q)); // R3
endmodule

// File: rtl/sdf_cmd.sv
`timescale 1ns/1ps
module sdf_cmd #(
  parameter int unsigned RSP_MAX = 16,
  parameter int unsigned LEN_W   = $clog2(RSP_MAX + 2)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 card_present,
  input  logic                 req,
  input  logic                 we,
  input  logic [7:0]           wbyte,
  output logic                 ack,
  output logic [7:0]           rbyte,
  output logic                 cmd_req,
  output logic [5:0]           cmd_index,
  output logic [31:0]          cmd_arg,
  output logic [7:0]           cmd_crc,
  input  logic                 cmd_rsp_valid,
  input  logic [LEN_W-1:0]     cmd_rsp_len,
  input  logic [RSP_MAX*8-1:0] cmd_rsp_data
);
  import sdf_pkg::*;

  localparam int unsigned BUF_DEPTH = RSP_MAX + 1;
  localparam int unsigned WP_W      = $clog2(CMD_BYTES);

  logic [7:0]       cbuf [CMD_BYTES-1];
  logic [WP_W-1:0]  wptr_q;
  logic             wait_q, ignore_q, req_q;
  logic [IDX_W-1:0] idx_q;
  logic [31:0]      arg_q;
  logic [7:0]       crc_q;
  logic [7:0]       rbuf [BUF_DEPTH];
  logic [LEN_W-1:0] rlen_q, rptr_q, rptr_inc, framed_len;
  logic [7:0]       frame [BUF_DEPTH];
  logic             last, wr_hit, rd_hit, issue_start, store_byte, drop, rsp_take;

  assign last        = (wptr_q == WP_W'(CMD_BYTES - 1));
  assign wr_hit      = req & we & card_present;
  assign rd_hit      = req & ~we & card_present;
  assign drop        = wr_hit & ignore_q;
  assign store_byte  = wr_hit & ~ignore_q & ~last;
  assign issue_start = wr_hit & ~ignore_q & last & ~wait_q;
  assign rsp_take    = wait_q & cmd_rsp_valid;
  assign ack = req & (~we | ~card_present | ignore_q | ~last | rsp_take);

  // response framing
  assign frame[0] = (cmd_rsp_len == LEN_W'(RSP_MAX)) ? LONG_LEAD : {2'b00, idx_q};
  for (genvar i = 1; i < BUF_DEPTH; i++) begin : g_frame
    assign frame[i] = (LEN_W'(i - 1) < cmd_rsp_len) ? cmd_rsp_data[(i-1)*8 +: 8] : 8'h00;
  end

  always_comb begin
    framed_len = cmd_rsp_len;
    if (cmd_rsp_len == LEN_W'(RSP_MAX))   framed_len = LEN_W'(RSP_MAX + 1);
    if (cmd_rsp_len == LEN_W'(RSP_SHORT)) framed_len = LEN_W'(RSP_SHORT + 2);
  end

  assign rptr_inc = rptr_q + 1'b1;
  assign rbyte = !card_present ? 8'hff :
                 (rptr_q < LEN_W'(BUF_DEPTH)) ? rbuf[rptr_q] : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr_q   <= '0;
      wait_q   <= 1'b0;
      ignore_q <= 1'b0;
      req_q    <= 1'b0;
      idx_q    <= '0;
      arg_q    <= '0;
      crc_q    <= '0;
      rlen_q   <= '0;
      rptr_q   <= '0;
      for (int k = 0; k < CMD_BYTES - 1; k++) cbuf[k] <= '0;
      for (int k = 0; k < BUF_DEPTH; k++)     rbuf[k] <= '0;
    end else begin
      req_q <= issue_start;
      if (store_byte) begin
        cbuf[wptr_q] <= wbyte;
        wptr_q       <= wptr_q + 1'b1;
      end
      if (drop) ignore_q <= 1'b0;
      if (issue_start) begin
        idx_q  <= cbuf[0][IDX_W-1:0];
        arg_q  <= {cbuf[1], cbuf[2], cbuf[3], cbuf[4]};
        crc_q  <= wbyte;
        wait_q <= 1'b1;
      end
      if (rsp_take) begin
        for (int k = 0; k < BUF_DEPTH; k++) rbuf[k] <= frame[k];
        rlen_q   <= framed_len;
        rptr_q   <= '0;
        wptr_q   <= '0;
        wait_q   <= 1'b0;
        ignore_q <= (idx_q == '0);
      end else if (rd_hit) begin
        rptr_q <= (rptr_inc > rlen_q) ? '0 : rptr_inc;
      end
    end
  end

  assign cmd_req   = req_q;
  assign cmd_index = idx_q;
  assign cmd_arg   = arg_q;
  assign cmd_crc   = crc_q;

  AST_CMD_STROBE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req |=> !cmd_req); // R4
  AST_WAIT_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    wait_q |-> last); // R4
  AST_RPTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rptr_q <= rlen_q); // R7
  AST_FRAME_LEN_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    rlen_q <= LEN_W'(BUF_DEPTH)); // R5
  AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> !ignore_q && $stable(wptr_q)); // R8
  AST_NO_CARD_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !card_present && !wait_q) |=> $stable(wptr_q) && $stable(rptr_q)); // R11
endmodule

// File: rtl/sdf_dat.sv
`timescale 1ns/1ps
module sdf_dat #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              card_present,
  input  logic              req,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_byte,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_byte
);
  localparam int unsigned BYTES = DATA_W / 8;
  localparam int unsigned CNT_W = $clog2(BYTES);

  logic [CNT_W-1:0]  cnt_q, sel;
  logic [DATA_W-9:0] shift_q;
  logic [DATA_W-1:0] tx_sh, rx_word;
  logic              active, beat, last;

  assign active   = req & card_present;
  assign tx_valid = active & we;
  assign rx_ready = active & ~we;
  assign sel      = CNT_W'(BYTES - 1) - cnt_q;
  assign tx_sh    = wdata >> {sel, 3'b000};
  assign tx_byte  = tx_sh[7:0];
  assign beat     = (tx_valid & tx_ready) | (rx_valid & rx_ready);
  assign last     = (cnt_q == CNT_W'(BYTES - 1));
  assign ack      = req & (~card_present | (beat & last));
  assign rx_word  = {shift_q, rx_byte};
  assign rdata    = card_present ? rx_word : '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      shift_q <= '0;
    end else if (beat) begin
      cnt_q <= last ? '0 : cnt_q + 1'b1;
      if (rx_ready) shift_q <= rx_word[DATA_W-9:0];
    end
  end

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> tx_valid && $stable(tx_byte)); // R10
  AST_CNT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !req |-> cnt_q == '0); // R9
endmodule

// File: rtl/sdcard_regfront.sv
`timescale 1ns/1ps
module sdcard_regfront #(
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned RSP_MAX = 16,
  parameter int unsigned LEN_W   = $clog2(RSP_MAX + 2)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 card_present,
  input  logic                 bus_valid,
  output logic                 bus_ready,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 cmd_req,
  output logic [5:0]           cmd_index,
  output logic [31:0]          cmd_arg,
  output logic [7:0]           cmd_crc,
  input  logic                 cmd_rsp_valid,
  input  logic [LEN_W-1:0]     cmd_rsp_len,
  input  logic [RSP_MAX*8-1:0] cmd_rsp_data,
  output logic                 dat_tx_valid,
  input  logic                 dat_tx_ready,
  output logic [7:0]           dat_tx_byte,
  input  logic                 dat_rx_valid,
  output logic                 dat_rx_ready,
  input  logic [7:0]           dat_rx_byte
);
  import sdf_pkg::*;

  logic              sel_cmd, sel_dat;
  logic              cmd_ack, dat_ack;
  logic [7:0]        cmd_rbyte;
  logic [DATA_W-1:0] reg_rd, dat_rd;

  assign sel_cmd = (bus_addr == ADDR_W'(OFS_CMD));
  assign sel_dat = (bus_addr == ADDR_W'(OFS_DAT));

  sdf_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(bus_valid & bus_we & ~sel_cmd & ~sel_dat),
    .addr(bus_addr), .wdata(bus_wdata), .rd_data(reg_rd)
  );

  sdf_cmd #(.RSP_MAX(RSP_MAX), .LEN_W(LEN_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .card_present(card_present),
    .req(bus_valid & sel_cmd), .we(bus_we), .wbyte(bus_wdata[7:0]),
    .ack(cmd_ack), .rbyte(cmd_rbyte),
    .cmd_req(cmd_req), .cmd_index(cmd_index), .cmd_arg(cmd_arg), .cmd_crc(cmd_crc),
    .cmd_rsp_valid(cmd_rsp_valid), .cmd_rsp_len(cmd_rsp_len), .cmd_rsp_data(cmd_rsp_data)
  );

  sdf_dat #(.DATA_W(DATA_W)) u_dat (
    .clk(clk), .rst_n(rst_n), .card_present(card_present),
    .req(bus_valid & sel_dat), .we(bus_we), .wdata(bus_wdata),
    .ack(dat_ack), .rdata(dat_rd),
    .tx_valid(dat_tx_valid), .tx_ready(dat_tx_ready), .tx_byte(dat_tx_byte),
    .rx_valid(dat_rx_valid), .rx_ready(dat_rx_ready), .rx_byte(dat_rx_byte)
  );

  assign bus_ready = sel_cmd ? cmd_ack : (sel_dat ? dat_ack : bus_valid);
  assign bus_rdata = sel_cmd ? {{(DATA_W-8){1'b0}}, cmd_rbyte} : (sel_dat ? dat_rd : reg_rd);

  AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |-> bus_valid); // R12
  AST_CMD_WAIT_FOR_CARD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req |-> !(bus_valid && sel_cmd && bus_ready && !cmd_rsp_valid)); // R4
endmodule

// File: tb/tb_sdcard_regfront.sv
`timescale 1ns/1ps
module tb_sdcard_regfront;
  logic clk = 1'b0, rst_n = 1'b0, card_present = 1'b1;
  logic bus_valid = 1'b0, bus_we = 1'b0, bus_ready;
  logic [2:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic cmd_req, cmd_rsp_valid = 1'b0;
  logic [5:0] cmd_index;
  logic [31:0] cmd_arg;
  logic [7:0] cmd_crc;
  logic [4:0] cmd_rsp_len;
  logic [127:0] next_data = '0;
  int next_len = 0, next_dly = 0;
  logic dat_tx_valid, dat_tx_ready = 1'b0, dat_rx_valid = 1'b0, dat_rx_ready;
  logic [7:0] dat_tx_byte, dat_rx_byte = '0;

  int n_chk = 0, n_err = 0, stall_cycles = 0;
  bit done = 0;

  assign cmd_rsp_len = 5'(next_len);

  sdcard_regfront dut (
    .clk(clk), .rst_n(rst_n), .card_present(card_present),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cmd_req(cmd_req), .cmd_index(cmd_index), .cmd_arg(cmd_arg), .cmd_crc(cmd_crc),
    .cmd_rsp_valid(cmd_rsp_valid), .cmd_rsp_len(cmd_rsp_len), .cmd_rsp_data(next_data),
    .dat_tx_valid(dat_tx_valid), .dat_tx_ready(dat_tx_ready), .dat_tx_byte(dat_tx_byte),
    .dat_rx_valid(dat_rx_valid), .dat_rx_ready(dat_rx_ready), .dat_rx_byte(dat_rx_byte)
  );

  always #2.5 clk = ~clk;

  // ---------------- card-side models ----------------
  int cap_n = 0, req_hi = 0, req_back2back = 0, rsp_cnt = 0;
  logic [5:0] cap_idx; logic [31:0] cap_arg; logic [7:0] cap_crc;
  int rx_seq = 0, tx_cnt = 0;
  logic [7:0] tx_log [0:1023];
  bit tx_fire_n = 0, rx_fire_n = 0, prev_req = 0;
  logic [7:0] tx_b_n;

  function automatic logic [7:0] rxf(input int n);
    return 8'(n * 29 + 7);
  endfunction

  always @(negedge clk) begin
    cmd_rsp_valid = 1'b0;
    if (cmd_req) begin
      cap_idx = cmd_index; cap_arg = cmd_arg; cap_crc = cmd_crc; cap_n++;
      req_hi++;
      if (prev_req) req_back2back++;
      if (next_dly == 0) cmd_rsp_valid = 1'b1; else rsp_cnt = next_dly;
    end else if (rsp_cnt > 0) begin
      rsp_cnt--;
      if (rsp_cnt == 0) cmd_rsp_valid = 1'b1;
    end
    prev_req = cmd_req;
    dat_rx_valid = ($urandom % 3) != 0;
    dat_tx_ready = ($urandom % 3) != 0;
    dat_rx_byte  = rxf(rx_seq);
  end

  always begin
    @(negedge clk); #1;
    tx_fire_n = dat_tx_valid & dat_tx_ready;
    tx_b_n    = dat_tx_byte;
    rx_fire_n = dat_rx_valid & dat_rx_ready;
  end

  always @(posedge clk) begin
    if (tx_fire_n) begin tx_log[tx_cnt % 1024] <= tx_b_n; tx_cnt <= tx_cnt + 1; end
    if (rx_fire_n) rx_seq <= rx_seq + 1;
  end

  // ---------------- checking helpers ----------------
  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic bus_xfer(input bit we, input logic [2:0] a, input logic [31:0] d,
                          output logic [31:0] q);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    #1;
    while (!bus_ready) begin stall_cycles++; @(negedge clk); #1; end
    q = bus_rdata;
    @(posedge clk); #1;
    bus_valid = 1'b0;
  endtask

  // ---------------- requirement model ----------------
  logic [7:0] m_cmd [0:5];
  logic [7:0] m_buf [0:17];
  int m_len = 0, m_rptr = 0, m_wptr = 0;
  bit m_ign = 0;
  logic [5:0] e_idx; logic [31:0] e_arg; logic [7:0] e_crc;

  function automatic bit m_write(input logic [7:0] b);
    if (!card_present) return 0;
    if (m_ign) begin m_ign = 0; return 0; end
    m_cmd[m_wptr] = b;
    m_wptr++;
    if (m_wptr < 6) return 0;
    m_wptr = 0;
    e_idx = m_cmd[0][5:0];
    e_arg = {m_cmd[1], m_cmd[2], m_cmd[3], m_cmd[4]};
    e_crc = m_cmd[5];
    for (int k = 1; k < 18; k++) m_buf[k] = (k - 1 < next_len) ? next_data[(k-1)*8 +: 8] : 8'h00;
    m_buf[0] = (next_len == 16) ? 8'h3f : {2'b00, e_idx};
    m_len = (next_len == 16) ? 17 : (next_len == 4) ? 6 : next_len;
    m_rptr = 0;
    m_ign = (e_idx == 0);
    return 1;
  endfunction

  function automatic logic [7:0] m_read();
    logic [7:0] r;
    if (!card_present) return 8'hff;
    r = m_buf[m_rptr];
    m_rptr++;
    if (m_rptr > m_len) m_rptr = 0;
    return r;
  endfunction

  task automatic cmd_wr(input logic [7:0] b, input string rq);
    logic [31:0] q; int n0; bit iss;
    n0 = cap_n;
    iss = m_write(b);
    bus_xfer(1'b1, 3'd4, {24'hABCDEF, b}, q);
    chk({rq, " issue count"}, cap_n, iss ? n0 + 1 : n0);
    if (iss) begin
      chk("R4 index", 32'(cap_idx), 32'(e_idx));
      chk("R4 argument", cap_arg, e_arg);
      chk("R4 crc", 32'(cap_crc), 32'(e_crc));
    end
  endtask

  task automatic cmd_rd(input string rq);
    logic [31:0] q; logic [7:0] e;
    e = m_read();
    bus_xfer(1'b0, 3'd4, 32'h0, q);
    chk(rq, q, {24'h0, e});
  endtask

  task automatic set_rsp(input int len);
    next_len = len;
    next_data = {$urandom, $urandom, $urandom, $urandom};
    next_dly = $urandom % 4;
  endtask

  task automatic full_cmd(input logic [7:0] b0, input int len);
    set_rsp(len);
    cmd_wr(b0, "R4");
    for (int k = 1; k < 6; k++) cmd_wr(8'($urandom), "R4");
  endtask

  task automatic dat_rd(input string rq);
    logic [31:0] q, e; int s;
    s = rx_seq;
    bus_xfer(1'b0, 3'd5, 32'h0, q);
    e = card_present ? {rxf(s), rxf(s+1), rxf(s+2), rxf(s+3)} : 32'hffffffff;
    chk(rq, q, e);
    chk({rq, " rx beats"}, rx_seq, card_present ? s + 4 : s);
  endtask

  task automatic dat_wr(input logic [31:0] w, input string rq);
    logic [31:0] q; int t;
    t = tx_cnt;
    bus_xfer(1'b1, 3'd5, w, q);
    @(negedge clk);
    chk({rq, " tx beats"}, tx_cnt, card_present ? t + 4 : t);
    if (card_present)
      chk(rq, {tx_log[t%1024], tx_log[(t+1)%1024], tx_log[(t+2)%1024], tx_log[(t+3)%1024]}, w);
  endtask

  task automatic reg_rw(input logic [2:0] a, input logic [31:0] w, input logic [31:0] e, input string rq);
    logic [31:0] q;
    bus_xfer(1'b1, a, w, q);
    bus_xfer(1'b0, a, 32'h0, q);
    chk(rq, q, e);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual running expected done");
    finish_run();
  end

  initial begin
    logic [31:0] q, v;
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      bus_xfer(1'b0, 3'(a), 32'h0, q);
      chk("R1 register reset", q, 32'h0);
    end
    cmd_rd("R1 command port after reset");
    cmd_rd("R1 command port after reset");
    chk("R1 no strobe", cap_n, 0);

    // R2 storage and unmapped offsets
    v = $urandom; reg_rw(3'd0, v, v, "R2 divider");
    v = $urandom; reg_rw(3'd3, v, v, "R2 start");
    reg_rw(3'd6, 32'hFFFF_FFFF, 32'h0, "R2 unmapped 6");
    reg_rw(3'd7, 32'h1234_5678, 32'h0, "R2 unmapped 7");
    bus_xfer(1'b0, 3'd3, 32'h0, q);
    chk("R2 start untouched by unmapped write", q, v);

    // R3 pending mirror
    reg_rw(3'd1, 32'hF, 32'hF, "R3 enable store");
    bus_xfer(1'b0, 3'd2, 32'h0, q); chk("R3 pending after enable", q, 32'hA);
    reg_rw(3'd2, 32'hF, 32'hA, "R3 pending write cannot clear");
    reg_rw(3'd1, 32'h5, 32'h5, "R3 enable store");
    bus_xfer(1'b0, 3'd2, 32'h0, q); chk("R3 pending cleared", q, 32'h0);
    reg_rw(3'd1, 32'hFFFF_FFF2, 32'hFFFF_FFF2, "R2 enable all bits");
    bus_xfer(1'b0, 3'd2, 32'h0, q); chk("R3 pending bit1 only", q, 32'h2);

    // R5 / R6 / R7 framing and read walk
    full_cmd(8'h51, 16);
    for (int k = 0; k < 20; k++) cmd_rd("R5 long frame walk");
    full_cmd(8'h4D, 4);
    for (int k = 0; k < 9; k++) cmd_rd("R6 short frame walk");
    full_cmd(8'h42, 2);
    for (int k = 0; k < 4; k++) cmd_rd("R6 other length walk");
    cmd_rd("R7 partial");
    full_cmd(8'h48, 4);
    cmd_rd("R7 restart after issue");

    // R8 ignore after index 0 (byte0 0xC0 masks to 0)
    full_cmd(8'hC0, 0);
    cmd_wr(8'h77, "R8 dropped write");
    full_cmd(8'h69, 4);
    cmd_rd("R8 following command framed");

    // R9 / R10 / R12 data port under stream gaps
    for (int k = 0; k < 6; k++) dat_rd("R9 data read");
    dat_wr(32'hA1B2C3D4, "R10 data write");
    for (int k = 0; k < 5; k++) dat_wr($urandom, "R10 data write");
    n_chk++;
    if (stall_cycles == 0) begin n_err++; $display("FAIL R12 actual 0 stalls expected >0"); end

    // R11 card absent
    full_cmd(8'h52, 16);
    cmd_rd("R11 before removal");
    cmd_rd("R11 before removal");
    card_present = 1'b0;
    for (int k = 0; k < 3; k++) cmd_rd("R11 absent command read");
    dat_rd("R11 absent data read");
    dat_wr(32'h0BAD_F00D, "R11 absent data write");
    for (int k = 0; k < 3; k++) cmd_wr(8'h3C, "R11 absent command write");
    card_present = 1'b1;
    cmd_rd("R11 read position kept");
    full_cmd(8'h4A, 4);
    cmd_rd("R11 write position kept");

    // constrained random mix
    for (int it = 0; it < 80; it++) begin
      case ($urandom % 6)
        0: begin v = $urandom; reg_rw(3'(($urandom % 2) * 3), v, v, "R2 random storage"); end
        1: begin v = $urandom; reg_rw(3'd1, v, v, "R2 random enable");
                 bus_xfer(1'b0, 3'd2, 32'h0, q); chk("R3 random pending", q, v & 32'hA); end
        2: begin
             int l;
             case ($urandom % 4) 0: l = 4; 1: l = 16; 2: l = 0; default: l = $urandom % 17; endcase
             full_cmd(8'($urandom), l);
           end
        3: dat_rd("R9 random data read");
        4: dat_wr($urandom, "R10 random data write");
        default: for (int k = 0; k < 1 + $urandom % 6; k++) cmd_rd("R7 random walk");
      endcase
    end

    chk("R4 one-cycle strobe", req_back2back, 0);
    chk("R4 strobe per issue", req_hi, cap_n);
    finish_run();
  end
endmodule